// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block drives the active-low reset line of a processor from three conditions. The first is a supply-good flag that an analog comparator outside the block has already brought into the clock domain. The second is an active-low manual reset pin, which may change at any time. The third is a one-cycle expiry pulse from a watchdog. Reset is held low for as long as any of these is active. Once all of them have cleared, reset stays low for a fixed number of clock cycles and is then released. Every new activation, including one that arrives during that countdown, starts a full new countdown.

The block also drives two status pins for a battery-seal sequencer. One is high while the countdown runs. The other gives a one-cycle strobe at the half-way point of the countdown and another at the three-quarter point. While the countdown runs and the sequencer holds its arm input high, the manual pin is ignored. There is no data stream here, so every pin is a plain level or pulse and none has a handshake. At 100 MHz the default length of 20,000,000 cycles gives a 200 ms pulse. A short length can be chosen for simulation.

Top module: `supply_reset_gen`

## Requirements
- R1: While `por_n` is low, `rst_out_n`, `tmo_busy` and `seal_strobe` are all 0. After `por_n` rises with no source active, `rst_out_n` stays 0 for exactly TIMEOUT_CYCLES cycles and then goes to 1.
- R2: A low `supply_ok` sampled at a clock edge drives `rst_out_n` to 0 from that edge on. It stays 0 for as long as `supply_ok` stays low, and `tmo_busy` stays 0 during that time.
- R3: Starting from the released state, a source held active for L clock edges gives exactly L + TIMEOUT_CYCLES cycles of `rst_out_n` = 0, followed by a release.
- R4: A drop of `supply_ok` during the countdown clears the count. After `supply_ok` returns, a full TIMEOUT_CYCLES countdown follows.
- R5: `mr_n` passes through SYNC_STAGES flops (2 by default) before it is used. A low pulse of L cycles gives L + TIMEOUT_CYCLES low cycles of reset, delayed by the synchronizer latency. With `seal_arm` = 0, a low pulse during the countdown restarts the countdown.
- R6: A one-cycle `wdog_expire` pulse gives exactly TIMEOUT_CYCLES + 1 low cycles of reset counted from the pulse, and this holds at every point of the countdown.
- R7: While the countdown runs and `seal_arm` = 1, a low on `mr_n` is ignored: reset is released in the same cycle it would have been without the pulse.
- R8: `seal_arm` masks `mr_n` only during the countdown. With reset released, a manual pulse still triggers a full reset even when `seal_arm` = 1.
- R9: `tmo_busy` is 1 in exactly the TIMEOUT_CYCLES cycles of the countdown and 0 while a source is held and while reset is released.
- R10: `seal_strobe` is high for one cycle at countdown cycle TIMEOUT_CYCLES/2 and for one cycle at countdown cycle 3*TIMEOUT_CYCLES/4. Cycle 0 is the first cycle in which `tmo_busy` is 1. A completed countdown gives exactly two strobes.
- R11: Once reset is released and no source is active, the count stays at its terminal value and does not wrap. `rst_out_n` stays 1 for as long as no source appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Active-low power-on reset of the logic, asynchronous |
| supply_ok | input | 1 | 1 = supply above the reset threshold (already synchronous) |
| mr_n | input | 1 | Active-low manual reset, asynchronous |
| wdog_expire | input | 1 | One-cycle watchdog expiry pulse |
| seal_arm | input | 1 | Seal arming condition from the sequencer; masks `mr_n` during the countdown |
| rst_out_n | output | 1 | Active-low processor reset |
| tmo_busy | output | 1 | 1 while the post-source countdown runs |
| seal_strobe | output | 1 | One-cycle strobe at the half and three-quarter points of the countdown |

## Verification
The bench builds the block with TIMEOUT_CYCLES = 16 and SYNC_STAGES = 2. The strobes therefore fall at countdown cycles 8 and 12, and a complete pulse takes only a few dozen cycles. With a length this short, the bench can sweep a supply drop, a watchdog pulse and a manual pulse, with the arm input both low and high, across every usable offset of the countdown. The expected low time for each offset is computed from the pulse length and the synchronizer latency.

// File: rtl/ssrg_pkg.sv
package ssrg_pkg;
  // Phase of the reset generator.
  typedef enum logic [1:0] {
    PH_HOLD  = 2'd0,  // a source is active, count held at zero
    PH_COUNT = 2'd1,  // all sources clear, counting toward release
    PH_RUN   = 2'd2   // reset released, count saturated
  } phase_e;
endpackage

// File: rtl/ssrg_sync.sv
module ssrg_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain[g] <= RST_VAL;
        else        chain[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain[g] <= RST_VAL;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ssrg_combine.sv
module ssrg_combine (
  input  logic supply_ok,
  input  logic mr_sync_n,
  input  logic wdog_expire,
  input  logic seal_arm,
  input  logic in_count,
  output logic hold_req
);
  logic manual_take;

  // Manual request is masked only while counting with the seal armed.
  always_comb begin
    manual_take = !mr_sync_n && !(in_count && seal_arm);
    hold_req    = !supply_ok || wdog_expire || manual_take;
  end
endmodule

// File: rtl/ssrg_timer.sv
module ssrg_timer
  import ssrg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic   clk,
  input  logic   por_n,
  input  logic   hold_req,
  output phase_e phase,
  output logic   strobe
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);
  localparam logic [CW-1:0] TERM = CW'(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] HALF = CW'(TIMEOUT_CYCLES / 2);
  localparam logic [CW-1:0] TQTR = CW'((3 * TIMEOUT_CYCLES) / 4);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase <= PH_HOLD;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          cnt <= '0;
          if (!hold_req) phase <= PH_COUNT;
        end
        PH_COUNT: begin
          if (hold_req) begin
            phase <= PH_HOLD;
            cnt   <= '0;
          end else if (cnt == LAST) begin
            phase <= PH_RUN;
            cnt   <= TERM;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          if (hold_req) begin
            phase <= PH_HOLD;
            cnt   <= '0;
          end
        end
      endcase
    end
  end

  assign strobe = (phase == PH_COUNT) && ((cnt == HALF) || (cnt == TQTR));

  // R4: any active source clears the count on the next edge
  p_hold_clears_r4: assert property (@(posedge clk) disable iff (!por_n)
    hold_req |=> (phase == PH_HOLD && cnt == '0))
    else $error("p_hold_clears_r4");

  // R3: release only directly after the last counting cycle
  p_release_after_last_r3: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_RUN && $past(phase) != PH_RUN) |->
      ($past(phase) == PH_COUNT && $past(cnt) == LAST))
    else $error("p_release_after_last_r3");

  // R3: counting advances by one per cycle
  p_count_step_r3: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_COUNT && !hold_req && cnt != LAST) |=> (cnt == $past(cnt) + CW'(1)))
    else $error("p_count_step_r3");

  // R11: released state is kept while no source appears
  p_saturate_r11: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_RUN && !hold_req) |=> (phase == PH_RUN && cnt == TERM))
    else $error("p_saturate_r11");

  // R10: each strobe lasts a single cycle
  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!por_n)
    strobe |=> !strobe)
    else $error("p_strobe_single_r10");
endmodule

// File: rtl/supply_reset_gen.sv
module supply_reset_gen
  import ssrg_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 20_000_000,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic supply_ok,
  input  logic mr_n,
  input  logic wdog_expire,
  input  logic seal_arm,
  output logic rst_out_n,
  output logic tmo_busy,
  output logic seal_strobe
);
  logic   mr_sync_n;
  logic   hold_req;
  phase_e phase;

  ssrg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_mr_sync (
    .clk   (clk),
    .por_n (por_n),
    .d     (mr_n),
    .q     (mr_sync_n)
  );

  ssrg_combine u_combine (
    .supply_ok   (supply_ok),
    .mr_sync_n   (mr_sync_n),
    .wdog_expire (wdog_expire),
    .seal_arm    (seal_arm),
    .in_count    (phase == PH_COUNT),
    .hold_req    (hold_req)
  );

  ssrg_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .clk      (clk),
    .por_n    (por_n),
    .hold_req (hold_req),
    .phase    (phase),
    .strobe   (seal_strobe)
  );

  assign rst_out_n = (phase == PH_RUN);
  assign tmo_busy  = (phase == PH_COUNT);

  // R2: low supply forces reset on the next edge
  p_supply_low_r2: assert property (@(posedge clk) disable iff (!por_n)
    !supply_ok |=> (!rst_out_n && !tmo_busy))
    else $error("p_supply_low_r2");

  // R6: a watchdog pulse always asserts reset
  p_wdog_resets_r6: assert property (@(posedge clk) disable iff (!por_n)
    wdog_expire |=> (!rst_out_n && !tmo_busy))
    else $error("p_wdog_resets_r6");

  // R7: armed seal keeps the countdown running past a manual request
  p_seal_masks_manual_r7: assert property (@(posedge clk) disable iff (!por_n)
    (tmo_busy && seal_arm && supply_ok && !wdog_expire) |=> (phase != PH_HOLD))
    else $error("p_seal_masks_manual_r7");
endmodule

// File: tb/sim_supply_reset_gen.sv
module sim_supply_reset_gen;
  localparam int T   = 16;
  localparam int WIN = 4 * T + 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic supply_ok = 1'b1;
  logic mr_n = 1'b1;
  logic wdog_expire = 1'b0;
  logic seal_arm = 1'b0;
  logic rst_out_n, tmo_busy, seal_strobe;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  supply_reset_gen #(.TIMEOUT_CYCLES(T), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_n(por_n), .supply_ok(supply_ok), .mr_n(mr_n),
    .wdog_expire(wdog_expire), .seal_arm(seal_arm),
    .rst_out_n(rst_out_n), .tmo_busy(tmo_busy), .seal_strobe(seal_strobe));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks = checks + 1;
    if (act != exp) begin
      failures = failures + 1;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // src: 0 supply, 1 manual, 2 watchdog, 3 none
  task automatic drive(input int src, input logic act);
    case (src)
      0: supply_ok = !act;
      1: mr_n = !act;
      2: wdog_expire = act;
      default: ;
    endcase
  endtask

  task automatic run_pulse(input int src, input int len, output int lows,
                           output int busys, output int nstr,
                           output int off1, output int off2);
    int fb;
    fb = -1; lows = 0; busys = 0; nstr = 0; off1 = -1; off2 = -1;
    if (len > 0) drive(src, 1'b1);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      if (!rst_out_n) lows++;
      if (tmo_busy) begin
        busys++;
        if (fb < 0) fb = i;
      end
      if (seal_strobe) begin
        nstr++;
        if (off1 < 0) off1 = i - fb;
        else if (off2 < 0) off2 = i - fb;
      end
      if (i == len - 1) drive(src, 1'b0);
    end
  endtask

  // Leaves the bench at countdown cycle k (negedge sample)
  task automatic enter_count(input int k);
    supply_ok = 1'b0;
    @(negedge clk);
    supply_ok = 1'b1;
    @(negedge clk);
    for (int j = 0; j < k; j++) @(negedge clk);
  endtask

  initial begin
    int lows, busys, nstr, o1, o2;

    // R1: state under power-on reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 rst_out_n in por", rst_out_n, 0);
      check("R1 tmo_busy in por", tmo_busy, 0);
      check("R1 seal_strobe in por", seal_strobe, 0);
    end
    por_n = 1'b1;
    run_pulse(3, 0, lows, busys, nstr, o1, o2);
    check("R1 low cycles after por", lows, T);
    check("R9 busy cycles after por", busys, T);
    check("R10 strobe count", nstr, 2);
    check("R10 first strobe offset", o1, T / 2);
    check("R10 second strobe offset", o2, (3 * T) / 4);

    // R11: stays released
    run_pulse(3, 0, lows, busys, nstr, o1, o2);
    check("R11 no reset while idle", lows, 0);
    check("R11 no busy while idle", busys, 0);
    check("R11 no strobe while idle", nstr, 0);

    // R2: held low supply
    supply_ok = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2 rst low with supply low", rst_out_n, 0);
      check("R2 busy low with supply low", tmo_busy, 0);
    end
    supply_ok = 1'b1;
    run_pulse(3, 0, lows, busys, nstr, o1, o2);
    check("R2 countdown after supply return", lows, T);

    // R3/R5/R6/R8: pulses of several lengths from the released state
    for (int len = 1; len <= 4; len++) begin
      run_pulse(0, len, lows, busys, nstr, o1, o2);
      check("R3 supply pulse low cycles", lows, len + T);
      check("R9 supply pulse busy cycles", busys, T);
      check("R10 supply pulse strobes", nstr, 2);
      run_pulse(2, len, lows, busys, nstr, o1, o2);
      check("R6 watchdog pulse low cycles", lows, len + T);
      run_pulse(1, len, lows, busys, nstr, o1, o2);
      check("R5 manual pulse low cycles", lows, len + T);
      check("R10 manual strobe offset", o1, T / 2);
      seal_arm = 1'b1;
      run_pulse(1, len, lows, busys, nstr, o1, o2);
      check("R8 manual honoured when released with seal armed", lows, len + T);
      seal_arm = 1'b0;
    end

    // Sweep of restarts across the countdown
    for (int k = 0; k <= T - 4; k++) begin
      enter_count(k);
      run_pulse(0, 1, lows, busys, nstr, o1, o2);
      check("R4 supply drop restarts countdown", lows, T + 1);
      check("R9 busy after supply restart", busys, T);

      enter_count(k);
      run_pulse(2, 1, lows, busys, nstr, o1, o2);
      check("R6 watchdog restarts countdown", lows, T + 1);

      enter_count(k);
      run_pulse(1, 1, lows, busys, nstr, o1, o2);
      check("R5 manual restarts countdown", lows, T + 3);
      check("R9 busy after manual restart", busys, T + 2);

      seal_arm = 1'b1;
      enter_count(k);
      run_pulse(1, 1, lows, busys, nstr, o1, o2);
      check("R7 manual ignored while armed", lows, T - 1 - k);
      check("R7 busy unchanged while armed", busys, T - 1 - k);
      seal_arm = 1'b0;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule